// File: doc/BRIEF.md
# Interleaved Half-Rate Serial Delay Line

This block is a fixed-length serial delay line. Its storage is not one long chain of flip-flops that moves every cycle. It is split into several shorter chains that take turns. A free-running phase counter picks one chain on each clock. Only that chain captures the incoming bit and advances; every other chain keeps its contents. As a result, each chain's flip-flops change state at only 1/WAYS of the input bit rate.

A multiplexer on the output reads the tail of the chain whose index equals the current phase. This rebuilds the full-rate stream in its original order. From the ports the block looks exactly like a plain DEPTH-stage shift register: same latency, same bit order. The total length DEPTH (default 16) and the interleave degree WAYS (1, 2 or 4) are parameters. Each chain holds DEPTH/WAYS stages.

It suits long serial delays where lower flip-flop activity is worth a small multiplexer on the output. Everything runs in one clock domain, with clock enables.

Top module: `interleaved_shreg`

## Requirements
- R1: The bit on `ser_i` at a rising clock edge appears on `ser_o` after DEPTH-1 further rising edges, and holds there for exactly one cycle. This makes `ser_o` identical, cycle by cycle, to the last stage of a plain DEPTH-stage shift register that is cleared by the same reset.
- R2: WAYS may be 1, 2 or 4, and DEPTH must be a multiple of WAYS. Each chain holds DEPTH/WAYS stages, and R1 holds for every allowed WAYS.
- R3: The phase counter counts 0, 1, …, WAYS-1 and then wraps to 0. It advances by one on every clock edge outside reset.
- R4: On each clock exactly one chain is enabled: the chain whose index equals the current phase value.
- R5: A chain that is not enabled keeps its stored bits unchanged through that clock edge.
- R6: `ser_o` is taken from the tail of the chain whose index equals the current phase. As a result, the position of a single marker bit at the output does not depend on how many cycles after reset it was injected.
- R7: While `rst_ni` is low, all chains and the phase counter are zero and `ser_o` reads 0. The reset acts asynchronously.
- R8: A reset applied in the middle of a stream discards every stored bit. After release, with zeros on the input, `ser_o` stays 0 for at least DEPTH cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Full-rate bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data in, one bit per clock |
| ser_o | output | 1 | Serial data out, delayed by DEPTH clocks |

## Verification
On every cycle, the assertions check the following:
- the output against an internal plain delay line;
- the phase counter's step-and-wrap sequence;
- that exactly one chain is enabled;
- that idle chain tails hold;
- that everything is cleared during reset.

Only the bench scenarios can show the following:
- the equivalence holds for all three interleave degrees built side by side;
- a marker bit lands on the same cycle whatever phase it was injected on;
- a reset in mid-stream really discards ones that were already stored in every chain.

// File: rtl/interleaved_shreg_pkg.sv
package interleaved_shreg_pkg;

    localparam int unsigned DEFAULT_DEPTH = 16;
    localparam int unsigned DEFAULT_WAYS  = 2;

    // Phase counter width; at least one bit so a single-chain build stays legal.
    function automatic int unsigned phase_width(input int unsigned ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/interleaved_shreg_phase.sv
module interleaved_shreg_phase
    import interleaved_shreg_pkg::*;
#(
    parameter int unsigned WAYS = DEFAULT_WAYS,
    localparam int unsigned PW  = phase_width(WAYS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output logic [PW-1:0]   phase_o,
    output logic [WAYS-1:0] en_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } phase_state_t;

    phase_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.cnt == PW'(WAYS - 1)) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = state_q.cnt;

    for (genvar g = 0; g < WAYS; g++) begin : g_en
        assign en_o[g] = (state_q.cnt == PW'(g));
    end

endmodule

// File: rtl/interleaved_shreg_chain.sv
module interleaved_shreg_chain #(
    parameter int unsigned LEN = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic d_i,
    output logic tail_o
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } chain_state_t;

    chain_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            state_d.bits = (state_q.bits << 1) | LEN'(d_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tail_o = state_q.bits[LEN-1];

endmodule

// File: rtl/interleaved_shreg_mux.sv
module interleaved_shreg_mux
    import interleaved_shreg_pkg::*;
#(
    parameter int unsigned WAYS = DEFAULT_WAYS,
    localparam int unsigned PW  = phase_width(WAYS)
) (
    input  logic [PW-1:0]   sel_i,
    input  logic [WAYS-1:0] tails_i,
    output logic            out_o
);

    always_comb begin
        out_o = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (sel_i == PW'(i)) begin
                out_o = tails_i[i];
            end
        end
    end

endmodule

// File: rtl/interleaved_shreg.sv
module interleaved_shreg
    import interleaved_shreg_pkg::*;
#(
    parameter int unsigned DEPTH = DEFAULT_DEPTH,
    parameter int unsigned WAYS  = DEFAULT_WAYS
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ser_i,
    output logic ser_o
);

    localparam int unsigned PW        = phase_width(WAYS);
    localparam int unsigned CHAIN_LEN = DEPTH / WAYS;

    // R2: only degrees 1, 2, 4 with an even split of DEPTH
    if (!(WAYS == 1 || WAYS == 2 || WAYS == 4) || (DEPTH % WAYS) != 0) begin : g_bad_cfg
        $error("interleaved_shreg: unsupported DEPTH/WAYS combination");
    end

    logic [PW-1:0]   phase_q;
    logic [WAYS-1:0] chain_en;
    logic [WAYS-1:0] chain_tail;

    interleaved_shreg_phase #(.WAYS(WAYS)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_o (phase_q),
        .en_o    (chain_en)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_chain
        interleaved_shreg_chain #(.LEN(CHAIN_LEN)) u_chain (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (chain_en[g]),
            .d_i    (ser_i),
            .tail_o (chain_tail[g])
        );
    end

    interleaved_shreg_mux #(.WAYS(WAYS)) u_mux (
        .sel_i   (phase_q),
        .tails_i (chain_tail),
        .out_o   (ser_o)
    );

endmodule

// File: rtl/interleaved_shreg_chk.sv
module interleaved_shreg_chk
    import interleaved_shreg_pkg::*;
#(
    parameter int unsigned DEPTH = DEFAULT_DEPTH,
    parameter int unsigned WAYS  = DEFAULT_WAYS,
    localparam int unsigned PW   = phase_width(WAYS)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            ser_i,
    input logic            ser_o,
    input logic [PW-1:0]   phase_i,
    input logic [WAYS-1:0] en_i,
    input logic [WAYS-1:0] tail_i
);

    // Plain delay line used as the yardstick for the interleaved store
    logic [DEPTH-1:0] plain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            plain_q <= '0;
        end else begin
            plain_q <= {plain_q[DEPTH-2:0], ser_i};
        end
    end

    AST_MATCHES_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_o == plain_q[DEPTH-1]) else $error("output differs from plain delay line"); // R1

    AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((int'($past(phase_i)) + 1) % WAYS) == int'(phase_i))
        else $error("phase did not advance by one"); // R3

    AST_ONE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(en_i) == 1) && (((en_i >> phase_i) & WAYS'(1)) != '0))
        else $error("enable is not the single chain at the current phase"); // R4

    for (genvar g = 0; g < WAYS; g++) begin : g_hold
        AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[g] |=> $stable(tail_i[g])) else $error("idle chain changed"); // R5
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |-> (ser_o == 1'b0 && phase_i == '0 && tail_i == '0))
        else $error("state not cleared in reset"); // R7

endmodule

bind interleaved_shreg interleaved_shreg_chk #(
    .DEPTH(DEPTH),
    .WAYS (WAYS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ser_i   (ser_i),
    .ser_o   (ser_o),
    .phase_i (phase_q),
    .en_i    (chain_en),
    .tail_i  (chain_tail)
);

// File: tb/test_interleaved_shreg.sv
module test_interleaved_shreg;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned NPAT  = 8;

    localparam logic [31:0] STIM [NPAT] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'hCCCC_3333,
        32'hA5A5_0F0F, 32'h8000_0001, 32'h1234_5678, 32'hF0E1_D2C3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0;
    logic out1, out2, out4;
    logic [DEPTH-1:0] ref_q;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    interleaved_shreg #(.DEPTH(DEPTH), .WAYS(1)) i_interleaved_shreg (
        .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .ser_o(out1));
    interleaved_shreg #(.DEPTH(DEPTH), .WAYS(2)) i_interleaved_shreg_w2 (
        .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .ser_o(out2));
    interleaved_shreg #(.DEPTH(DEPTH), .WAYS(4)) i_interleaved_shreg_w4 (
        .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .ser_o(out4));

    // Reference: plain serial shift register of the same length
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= {ref_q[DEPTH-2:0], ser};
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag, input logic exp);
        check_bit({tag, " ways=1"}, out1, exp);
        check_bit({tag, " ways=2"}, out2, exp);
        check_bit({tag, " ways=4"}, out4, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ser = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: done=0 expected 1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R7: reset state
        #1;
        check_all("R7 during reset", 1'b0);
        do_reset();
        check_all("R7 after release", 1'b0);

        // R1 R2 R5: table walk against the plain reference, every cycle
        for (int p = 0; p < NPAT; p++) begin
            for (int b = 31; b >= 0; b--) begin
                ser = STIM[p][b];
                @(negedge clk);
                check_all("R1 R2 R5 table", ref_q[DEPTH-1]);
            end
        end

        // R3 R4 R6: marker injected at each phase offset lands DEPTH cycles later
        for (int off = 0; off < 5; off++) begin
            do_reset();
            repeat (off) @(negedge clk);
            ser = 1'b1;
            for (int k = 1; k <= DEPTH + 2; k++) begin
                @(negedge clk);
                ser = 1'b0;
                check_all("R3 R4 R6 marker", (k == DEPTH) ? 1'b1 : 1'b0);
            end
        end

        // R8: reset in mid-stream discards stored ones
        ser = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        check_all("R8 primed", 1'b1);
        rst_n = 1'b0;
        #1;
        check_all("R7 async clear", 1'b0);
        ser = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk);
            check_all("R8 flushed", 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule